// File: doc/BRIEF.md
# Interrupt Vector Receive Register

This block holds the pending-interrupt vector of one hardware thread, one bit per interrupt number. Interrupt sources set bits directly through a wide set input. Software reaches the vector through a small access port. A two-bit select code picks one of three registers. The receive register can be read whole, and a write to it clears the chosen bits. The acknowledge register is read-only: a read returns the number of the highest pending interrupt and retires it in the same step. The dispatch register is write-only: a write sends an interrupt to another thread over an outgoing post request.

Every access carries two privilege flags. Only a hyperprivileged access is serviced. Any other access is refused with one of two error kinds, and a fault-status update pulse is raised. Direction rules are also enforced: an access in the wrong direction, or to the unused select code, ends in a data-access error. A refused access changes nothing. All responses and post requests are registered and appear one clock after the access is sampled.

Top module: `intvec_recv`

## Requirements
- R1: While `rst` is high, the pending vector is cleared and `rsp_valid`, `post_valid` and `fault_upd` are low on the following cycle.
- R2: A bit set on `irq_set` in one cycle is pending in `pend_vec` on the next cycle.
- R3: Each access sampled with `acc_valid` high produces exactly one cycle of `rsp_valid` on the next cycle. No response follows an idle cycle.
- R4: A read with select code 0 (receive) returns the whole pending vector as it stood before that cycle's update, and leaves it unchanged.
- R5: A read with select code 1 (acknowledge) returns the index of the most significant pending bit, zero-extended. It clears that bit and no other.
- R6: An acknowledge read with nothing pending returns 0 and leaves the vector unchanged.
- R7: A write with select code 0 clears each pending bit that is 1 in `acc_wdata`. All other bits are unchanged. `rsp_rdata` is 0 for writes.
- R8: When a hardware set and a software clear target the same bit in the same cycle, the bit ends up pending.
- R9: An access with `acc_hpriv` low is refused. `rsp_err` and `fault_upd` go high, and `rsp_err_kind` is 0 (data access) if `acc_priv` is high and 1 (privileged action) otherwise.
- R10: A hyperprivileged write with select code 1, a read with select code 2, or any access with select code 3 is refused with `rsp_err_kind` 0 and `fault_upd` high.
- R11: A hyperprivileged write with select code 2 (dispatch) pulses `post_valid` for one cycle on the next cycle. `post_thread` carries `acc_wdata[12:8]` and `post_vector` carries `acc_wdata[5:0]`.
- R12: A refused access neither changes the pending vector nor raises `post_valid`. Its `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | 64 | Hardware interrupt set bits, one per vector number |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_sel | input | 2 | Register select: 0 receive, 1 acknowledge, 2 dispatch, 3 unused |
| acc_wdata | input | 64 | Write data |
| acc_hpriv | input | 1 | Hyperprivileged flag of the access |
| acc_priv | input | 1 | Privileged flag of the access |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access refused |
| rsp_err_kind | output | 1 | 0 data-access error, 1 privileged-action error |
| fault_upd | output | 1 | Fault status update pulse |
| post_valid | output | 1 | Outgoing interrupt post request |
| post_thread | output | 5 | Target thread number |
| post_vector | output | 6 | Vector number to post |
| pend_vec | output | 64 | Current pending vector |

## Verification
The acknowledge path is driven with a vector that has its top bit and two low bits pending, so successive reads must walk down through 63, then 4, then 0. This separates a true most-significant search from a lowest-first search or an off-by-one index. Receive-register writes use masks that overlap the pending set only in part, which exposes any clear that touches unmasked bits. A write whose mask collides with a same-cycle hardware set checks that the set takes priority. Every refused case is run with pending bits present, covering each privilege pairing, each wrong direction and the unused code. This shows that an error leaves state and the post request untouched, and that the error kind follows the privileged flag.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  typedef enum logic [1:0] {
    SEL_RCV  = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_DSP  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic ERR_DATA = 1'b0;
  localparam logic ERR_PRIV = 1'b1;

  // bit position of the thread field inside dispatch write data
  localparam int THR_LSB = 8;

endpackage

// File: rtl/intvec_gate.sv
module intvec_gate
  import intvec_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [1:0] sel,
  input  logic       hpriv,
  input  logic       priv,
  output logic       ok_rcv_rd,
  output logic       ok_rcv_wr,
  output logic       ok_ack,
  output logic       ok_dsp,
  output logic       err,
  output logic       err_kind
);

  logic bad_dir;

  always_comb begin
    bad_dir = 1'b0;
    case (sel_e'(sel))
      SEL_RCV:  bad_dir = 1'b0;
      SEL_ACK:  bad_dir = write;
      SEL_DSP:  bad_dir = !write;
      default:  bad_dir = 1'b1;
    endcase
  end

  always_comb begin
    ok_rcv_rd = 1'b0;
    ok_rcv_wr = 1'b0;
    ok_ack    = 1'b0;
    ok_dsp    = 1'b0;
    err       = 1'b0;
    err_kind  = ERR_DATA;
    if (valid) begin
      if (!hpriv) begin
        err      = 1'b1;
        err_kind = priv ? ERR_DATA : ERR_PRIV;
      end else if (bad_dir) begin
        err      = 1'b1;
        err_kind = ERR_DATA;
      end else begin
        ok_rcv_rd = (sel == SEL_RCV) && !write;
        ok_rcv_wr = (sel == SEL_RCV) && write;
        ok_ack    = (sel == SEL_ACK);
        ok_dsp    = (sel == SEL_DSP);
      end
    end
  end

endmodule

// File: rtl/intvec_msb.sv
module intvec_msb #(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < VEC_W; i++) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/intvec_store.sv
module intvec_store #(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] set_bits,
  input  logic [VEC_W-1:0] clr_bits,
  output logic [VEC_W-1:0] pend
);

  // set is merged after the clear, so a collision leaves the bit pending
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_bits) | set_bits;
  end

endmodule

// File: rtl/intvec_recv.sv
module intvec_recv
  import intvec_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int THR_W = 5,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] irq_set,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_sel,
  input  logic [VEC_W-1:0] acc_wdata,
  input  logic             acc_hpriv,
  input  logic             acc_priv,
  output logic             rsp_valid,
  output logic [VEC_W-1:0] rsp_rdata,
  output logic             rsp_err,
  output logic             rsp_err_kind,
  output logic             fault_upd,
  output logic             post_valid,
  output logic [THR_W-1:0] post_thread,
  output logic [IDX_W-1:0] post_vector,
  output logic [VEC_W-1:0] pend_vec
);

  logic             ok_rcv_rd, ok_rcv_wr, ok_ack, ok_dsp, g_err, g_kind;
  logic [IDX_W-1:0] top_idx;
  logic             top_any;
  logic [VEC_W-1:0] clr_bits;
  logic [VEC_W-1:0] rdata_nxt;

  intvec_gate u_gate (
    .valid     (acc_valid),
    .write     (acc_write),
    .sel       (acc_sel),
    .hpriv     (acc_hpriv),
    .priv      (acc_priv),
    .ok_rcv_rd (ok_rcv_rd),
    .ok_rcv_wr (ok_rcv_wr),
    .ok_ack    (ok_ack),
    .ok_dsp    (ok_dsp),
    .err       (g_err),
    .err_kind  (g_kind)
  );

  intvec_msb #(.VEC_W(VEC_W)) u_msb (
    .vec (pend_vec),
    .idx (top_idx),
    .any (top_any)
  );

  always_comb begin
    clr_bits = '0;
    if (ok_rcv_wr)
      clr_bits = acc_wdata;
    else if (ok_ack && top_any)
      clr_bits = {{(VEC_W-1){1'b0}}, 1'b1} << top_idx;
  end

  always_comb begin
    rdata_nxt = '0;
    if (ok_rcv_rd)
      rdata_nxt = pend_vec;
    else if (ok_ack)
      rdata_nxt = {{(VEC_W-IDX_W){1'b0}}, top_idx};
  end

  intvec_store #(.VEC_W(VEC_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .set_bits (irq_set),
    .clr_bits (clr_bits),
    .pend     (pend_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_err      <= 1'b0;
      rsp_err_kind <= ERR_DATA;
      fault_upd    <= 1'b0;
      post_valid   <= 1'b0;
      post_thread  <= '0;
      post_vector  <= '0;
    end else begin
      rsp_valid    <= acc_valid;
      rsp_rdata    <= rdata_nxt;
      rsp_err      <= g_err;
      rsp_err_kind <= g_kind;
      fault_upd    <= g_err;
      post_valid   <= ok_dsp;
      if (ok_dsp) begin
        post_thread <= acc_wdata[THR_LSB +: THR_W];
        post_vector <= acc_wdata[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/intvec_recv_chk.sv
module intvec_recv_chk
  import intvec_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int THR_W = 5,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input logic             clk,
  input logic             rst,
  input logic [VEC_W-1:0] irq_set,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [1:0]       acc_sel,
  input logic [VEC_W-1:0] acc_wdata,
  input logic             acc_hpriv,
  input logic             acc_priv,
  input logic             rsp_valid,
  input logic [VEC_W-1:0] rsp_rdata,
  input logic             rsp_err,
  input logic             rsp_err_kind,
  input logic             fault_upd,
  input logic             post_valid,
  input logic [THR_W-1:0] post_thread,
  input logic [IDX_W-1:0] post_vector,
  input logic [VEC_W-1:0] pend_vec
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pend_vec == '0 && !rsp_valid && !post_valid && !fault_upd));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (|irq_set) |=> ((pend_vec & $past(irq_set)) == $past(irq_set)));

  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  p_no_rsp_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid);

  p_ack_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_hpriv && acc_sel == SEL_ACK && irq_set == '0)
      |=> ($countones($past(pend_vec) ^ pend_vec) <= 1));

  p_write_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_hpriv && acc_sel == SEL_RCV && irq_set == '0)
      |=> (pend_vec == ($past(pend_vec) & ~$past(acc_wdata))));

  p_priv_kind_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hpriv)
      |=> (rsp_err && fault_upd && rsp_err_kind == !$past(acc_priv)));

  p_post_source_r11: assert property (@(posedge clk) disable iff (rst)
    post_valid |-> $past(acc_valid && acc_write && acc_hpriv && acc_sel == SEL_DSP));

  p_err_no_post_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!post_valid && rsp_rdata == '0));

  p_err_keeps_state_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hpriv && irq_set == '0) |=> $stable(pend_vec));

  // post_thread/post_vector only carry meaning while post_valid is high
  p_post_fields_known_r11: assert property (@(posedge clk) disable iff (rst)
    post_valid |-> (!$isunknown(post_thread) && !$isunknown(post_vector)));

endmodule

bind intvec_recv intvec_recv_chk #(.VEC_W(VEC_W), .THR_W(THR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_set      (irq_set),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_sel      (acc_sel),
  .acc_wdata    (acc_wdata),
  .acc_hpriv    (acc_hpriv),
  .acc_priv     (acc_priv),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_err      (rsp_err),
  .rsp_err_kind (rsp_err_kind),
  .fault_upd    (fault_upd),
  .post_valid   (post_valid),
  .post_thread  (post_thread),
  .post_vector  (post_vector),
  .pend_vec     (pend_vec)
);

// File: tb/intvec_recv_bench.sv
`timescale 1ns/1ps
module intvec_recv_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_set = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_hpriv = 1'b0, acc_priv = 1'b0;
  logic [1:0]  acc_sel = 2'd0;
  logic [63:0] acc_wdata = '0;
  logic        rsp_valid, rsp_err, rsp_err_kind, fault_upd, post_valid;
  logic [63:0] rsp_rdata, pend_vec;
  logic [4:0]  post_thread;
  logic [5:0]  post_vector;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intvec_recv u_intvec_recv (
    .clk(clk), .rst(rst), .irq_set(irq_set), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_hpriv(acc_hpriv), .acc_priv(acc_priv), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_err_kind(rsp_err_kind),
    .fault_upd(fault_upd), .post_valid(post_valid), .post_thread(post_thread),
    .post_vector(post_vector), .pend_vec(pend_vec)
  );

  typedef struct packed {
    logic        vld;
    logic        wr;
    logic [1:0]  sel;
    logic        hp;
    logic        pr;
    logic [63:0] set;
    logic [63:0] wd;
    logic        err;
    logic        kind;
    logic [63:0] rd;
    logic [63:0] pend;
    logic        post;
    logic [4:0]  thr;
    logic [5:0]  vec;
  } row_t;

  localparam int NROW = 14;
  localparam row_t ROWS [0:NROW-1] = '{
    '{1'b0,1'b0,2'd0,1'b0,1'b0, 64'h8000_0000_0000_0011, 64'h0, 1'b0,1'b0, 64'h0, 64'h8000_0000_0000_0011, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd0,1'b1,1'b0, 64'h0, 64'h0, 1'b0,1'b0, 64'h8000_0000_0000_0011, 64'h8000_0000_0000_0011, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd1,1'b1,1'b0, 64'h0, 64'h0, 1'b0,1'b0, 64'd63, 64'h11, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd1,1'b1,1'b0, 64'h0, 64'h0, 1'b0,1'b0, 64'd4, 64'h1, 1'b0,5'h0,6'h0},
    '{1'b1,1'b1,2'd0,1'b1,1'b0, 64'hF00, 64'h101, 1'b0,1'b0, 64'h0, 64'hF00, 1'b0,5'h0,6'h0},
    '{1'b1,1'b1,2'd0,1'b1,1'b0, 64'h0, 64'h300, 1'b0,1'b0, 64'h0, 64'hC00, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd1,1'b0,1'b1, 64'h0, 64'h0, 1'b1,1'b0, 64'h0, 64'hC00, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd0,1'b0,1'b0, 64'h0, 64'h0, 1'b1,1'b1, 64'h0, 64'hC00, 1'b0,5'h0,6'h0},
    '{1'b1,1'b1,2'd1,1'b1,1'b0, 64'h0, 64'hFFFF, 1'b1,1'b0, 64'h0, 64'hC00, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd2,1'b1,1'b0, 64'h0, 64'h0, 1'b1,1'b0, 64'h0, 64'hC00, 1'b0,5'h0,6'h0},
    '{1'b1,1'b1,2'd2,1'b1,1'b0, 64'h0, 64'h1F2A, 1'b0,1'b0, 64'h0, 64'hC00, 1'b1,5'h1F,6'h2A},
    '{1'b1,1'b1,2'd0,1'b1,1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0,1'b0, 64'h0, 64'h0, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd1,1'b1,1'b0, 64'h0, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0,5'h0,6'h0},
    '{1'b1,1'b0,2'd3,1'b1,1'b0, 64'h0, 64'h0, 1'b1,1'b0, 64'h0, 64'h0, 1'b0,5'h0,6'h0}
  };

  function automatic string row_tag(int i);
    case (i)
      0:       return "R2";
      1:       return "R4";
      2, 3:    return "R5";
      4:       return "R8";
      5, 11:   return "R7";
      6, 7:    return "R9";
      10:      return "R11";
      12:      return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic v, logic w, logic [1:0] s, logic h, logic p,
                       logic [63:0] st, logic [63:0] d);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_sel = s; acc_hpriv = h; acc_priv = p;
    irq_set = st; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; irq_set = '0; acc_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pend", pend_vec, 64'h0);
    chk("R1", "rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R1", "post_valid", {63'h0, post_valid}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      drive(ROWS[i].vld, ROWS[i].wr, ROWS[i].sel, ROWS[i].hp, ROWS[i].pr,
            ROWS[i].set, ROWS[i].wd);
      chk(row_tag(i), "rsp_valid", {63'h0, rsp_valid}, {63'h0, ROWS[i].vld});
      chk(row_tag(i), "pend", pend_vec, ROWS[i].pend);
      chk(row_tag(i), "post_valid", {63'h0, post_valid}, {63'h0, ROWS[i].post});
      if (ROWS[i].vld) begin
        chk(row_tag(i), "rdata", rsp_rdata, ROWS[i].rd);
        chk(row_tag(i), "err", {63'h0, rsp_err}, {63'h0, ROWS[i].err});
        chk(row_tag(i), "fault_upd", {63'h0, fault_upd}, {63'h0, ROWS[i].err});
        if (ROWS[i].err)
          chk(row_tag(i), "err_kind", {63'h0, rsp_err_kind}, {63'h0, ROWS[i].kind});
      end
      if (ROWS[i].post) begin
        chk(row_tag(i), "thread", {59'h0, post_thread}, {59'h0, ROWS[i].thr});
        chk(row_tag(i), "vector", {58'h0, post_vector}, {58'h0, ROWS[i].vec});
      end
    end

    // R3: response lasts one cycle only
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_sel = 2'd0; acc_hpriv = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R3", "rsp_valid first", {63'h0, rsp_valid}, 64'h1);
    @(negedge clk);
    chk("R3", "rsp_valid second", {63'h0, rsp_valid}, 64'h0);

    // R12: refused dispatch and refused clear leave everything alone
    drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 64'h00F0, 64'h0);
    drive(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 64'h0, 64'h0305);
    chk("R12", "post_valid", {63'h0, post_valid}, 64'h0);
    chk("R12", "err_kind", {63'h0, rsp_err_kind}, 64'h1);
    drive(1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 64'h0, 64'hFFFF);
    chk("R12", "pend", pend_vec, 64'h00F0);
    chk("R12", "rdata", rsp_rdata, 64'h0);

    // R5: acknowledge of bit 0 alone
    drive(1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 64'h1, 64'h00F0);
    drive(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 64'h0, 64'h0);
    chk("R5", "rdata bit0", rsp_rdata, 64'h0);
    chk("R5", "pend bit0", pend_vec, 64'h0);

    // R1: reset in mid-run clears pending bits
    drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 64'hA5A5, 64'h0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "pend after reset", pend_vec, 64'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule